// File: doc/BRIEF.md
# Quadrature Position Counter with Write-Protected Configuration

This block turns the two phase outputs of an incremental encoder, phase A and phase B, into a 16-bit position count. Software controls it through a small register bus. It can set a lower bound (the start value) and an upper bound (the limit value), choose a power-of-two event divider, and switch decoding on. Each edge of either phase is one decode event, so the block counts four times per encoder cycle. The direction of each event follows the Gray order of the two phases. The count wraps between the start value and the limit value.

The configuration is guarded in two ways. A sticky lock, set from the status register, makes the block ignore writes to the configuration registers. The only way to release the lock is a dedicated unlock bit in the mode register. A master enable bit in the mode register must also be 1 before the start and limit registers accept a write. A write to the count register never stores its data. It reloads the counter with the start value.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the registers read as follows: count 0, start value 0x0000, limit value 0xFFFF, divider 0, decode enable 0, lock 0, error 0 and master enable 0.
- R2: While decoding is enabled, each step of the phase pair {A,B} along 00→01→11→10→00 adds one to the count, and each step in the reverse order subtracts one. The new count can be read within four clock edges after the phase change.
- R3: A bus write to address 0x00 loads the start value into the count, whatever the write data.
- R4: An up event taken at the limit value loads the start value. A down event taken at the start value loads the limit value.
- R5: With divider field PS (address 0x0C, bits 2:0), the count changes once for every 2^PS decode events. Every accepted write to the divider register clears the partial event accumulation.
- R6: While decode enable (address 0x14, bit 0) is 0, phase edges leave the count unchanged.
- R7: Writing 1 to status bit 0 (address 0x18) sets the lock, and the lock can be read back in that bit. While the lock is set, writes to the divider, decode-enable, mode, start and limit registers are ignored.
- R8: While the lock is set, a mode-register write (address 0x10) with bit 2 set clears the lock and leaves master enable (bit 0) unchanged.
- R9: Writes to the start (0x04) and limit (0x08) registers take effect only while master enable is 1.
- R10: A change of both phases in one step leaves the count unchanged and sets the sticky error bit, status bit 1.
- R11: Reads are combinational and zero-extended: 0x00 count, 0x04 start, 0x08 limit, 0x0C divider, 0x10 master enable in bit 0, 0x14 decode enable, 0x18 lock in bit 0 and error in bit 1. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |

## Verification
The hardest case to reach is the divider accumulation. It is state that cannot be seen from the ports. The bench reaches it by leaving a partial count of events, rewriting the same divider value, and then counting how many further events it takes before the count moves. The lock is handled the same way. Each ignored write is followed by a read of the register it targeted, and by phase edges that show decoding is still active.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PS_W   = 3;
    localparam int ACC_W  = (1 << PS_W) - 1;

    localparam logic [ADDR_W-1:0] A_COUNT = 8'h00;
    localparam logic [ADDR_W-1:0] A_START = 8'h04;
    localparam logic [ADDR_W-1:0] A_LIMIT = 8'h08;
    localparam logic [ADDR_W-1:0] A_DIV   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_MODE  = 8'h10;
    localparam logic [ADDR_W-1:0] A_QCTL  = 8'h14;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h18;

    localparam int MODE_MEN_BIT   = 0;
    localparam int MODE_UNLCK_BIT = 2;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_BAD  = 2'd2,
        STEP_DN   = 2'd3
    } step_e;

    typedef struct packed {
        logic [CNT_W-1:0] start_val;
        logic [CNT_W-1:0] limit_val;
        logic [PS_W-1:0]  div_sel;
        logic             men;
        logic             qen;
        logic             lock;
    } qdec_cfg_t;

    // Position of a phase pair {A,B} on the Gray cycle 00,01,11,10
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        return {ab[1], ab[1] ^ ab[0]};
    endfunction

    function automatic step_e classify(input logic [1:0] old_ab, input logic [1:0] new_ab);
        logic [1:0] d;
        d = gray_pos(new_ab) - gray_pos(old_ab);
        return step_e'(d);
    endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ab_sync,
    input  logic       en,
    output logic       ev_up,
    output logic       ev_dn,
    output logic       ev_bad
);
    logic [1:0] prev_q;
    step_e      kind;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= ab_sync;
    end

    assign kind   = classify(prev_q, ab_sync);
    assign ev_up  = en && (kind == STEP_UP);
    assign ev_dn  = en && (kind == STEP_DN);
    assign ev_bad = en && (kind == STEP_BAD);

    // R2: a single decode event never points both ways
    p_one_dir_r2: assert property (@(posedge clk) disable iff (rst)
        !(ev_up && ev_dn));

    // R10: a double change never yields a count event
    p_bad_no_event_r10: assert property (@(posedge clk) disable iff (rst)
        (ab_sync == ~prev_q) |-> !(ev_up || ev_dn));
endmodule

// File: rtl/qdec_prescale.sv
module qdec_prescale
    import qdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PS_W-1:0] div_sel,
    input  logic            clr,
    input  logic            in_up,
    input  logic            in_dn,
    output logic            out_up,
    output logic            out_dn
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] lim;
    logic             ev;
    logic             fire;

    assign lim  = ACC_W'((1 << div_sel) - 1);
    assign ev   = in_up || in_dn;
    assign fire = ev && (acc_q == lim) && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr)  acc_q <= '0;
        else if (fire)   acc_q <= '0;
        else if (ev)     acc_q <= acc_q + 1'b1;
    end

    assign out_up = fire && in_up;
    assign out_dn = fire && in_dn;

    // R5: a divider write empties the accumulator
    p_acc_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

    // R5: accumulator stays within the selected division
    p_acc_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_q <= lim) || $changed(div_sel));
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    input  logic             reload,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] limit_val,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (reload) cnt_q <= start_val;
        else if (inc)    cnt_q <= (cnt_q == limit_val) ? start_val : cnt_q + 1'b1;
        else if (dec)    cnt_q <= (cnt_q == start_val) ? limit_val : cnt_q - 1'b1;
    end

    assign cnt = cnt_q;

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == $past(start_val)));

    p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && !reload && cnt_q == limit_val) |=> (cnt_q == $past(start_val)));

    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !reload && cnt_q == start_val) |=> (cnt_q == $past(limit_val)));

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (inc && !reload && cnt_q != limit_val) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/qdec_regs.sv
module qdec_regs
    import qdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              bad_ev,
    output qdec_cfg_t         cfg,
    output logic              div_clr,
    output logic              cnt_reload,
    output logic [DATA_W-1:0] rdata
);
    qdec_cfg_t cfg_q;
    logic      err_q;
    logic      wr_open;
    logic      wr_window;
    logic      unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:CNT_W];
    assign wr_open   = wr && !cfg_q.lock;
    assign wr_window = wr_open && cfg_q.men;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.start_val <= '0;
            cfg_q.limit_val <= '1;
            cfg_q.div_sel   <= '0;
            cfg_q.men       <= 1'b0;
            cfg_q.qen       <= 1'b0;
            cfg_q.lock      <= 1'b0;
            err_q           <= 1'b0;
        end else begin
            if (bad_ev) err_q <= 1'b1;
            if (wr_window && addr == A_START) cfg_q.start_val <= wdata[CNT_W-1:0];
            if (wr_window && addr == A_LIMIT) cfg_q.limit_val <= wdata[CNT_W-1:0];
            if (wr_open && addr == A_DIV)     cfg_q.div_sel   <= wdata[PS_W-1:0];
            if (wr_open && addr == A_QCTL)    cfg_q.qen       <= wdata[0];
            if (wr && addr == A_MODE) begin
                if (cfg_q.lock) begin
                    if (wdata[MODE_UNLCK_BIT]) cfg_q.lock <= 1'b0;
                end else begin
                    cfg_q.men <= wdata[MODE_MEN_BIT];
                end
            end
            if (wr && addr == A_STAT && wdata[0]) cfg_q.lock <= 1'b1;
        end
    end

    assign cfg        = cfg_q;
    assign div_clr    = wr_open && addr == A_DIV;
    assign cnt_reload = wr && addr == A_COUNT;

    always_comb begin
        rdata = '0;
        case (addr)
            A_COUNT: rdata[CNT_W-1:0] = cnt;
            A_START: rdata[CNT_W-1:0] = cfg_q.start_val;
            A_LIMIT: rdata[CNT_W-1:0] = cfg_q.limit_val;
            A_DIV:   rdata[PS_W-1:0]  = cfg_q.div_sel;
            A_MODE:  rdata[MODE_MEN_BIT] = cfg_q.men;
            A_QCTL:  rdata[0] = cfg_q.qen;
            A_STAT:  rdata[1:0] = {err_q, cfg_q.lock};
            default: rdata = '0;
        endcase
    end

    p_lock_div_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lock && wr && addr == A_DIV) |=> $stable(cfg_q.div_sel));

    p_lock_qen_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lock && wr && addr == A_QCTL) |=> $stable(cfg_q.qen));

    p_unlock_keeps_men_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lock && wr && addr == A_MODE) |=> $stable(cfg_q.men));

    p_men_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.men && wr && addr == A_LIMIT) |=> $stable(cfg_q.limit_val));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              enc_a,
    input  logic              enc_b
);
    qdec_cfg_t        cfg;
    logic [1:0]       ab_s;
    logic             ev_up, ev_dn, ev_bad;
    logic             cnt_up, cnt_dn;
    logic             div_clr, cnt_reload;
    logic [CNT_W-1:0] cnt;

    qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async({enc_a, enc_b}), .q_sync(ab_s)
    );

    qdec_decode u_dec (
        .clk(clk), .rst(rst), .ab_sync(ab_s), .en(cfg.qen),
        .ev_up(ev_up), .ev_dn(ev_dn), .ev_bad(ev_bad)
    );

    qdec_prescale u_div (
        .clk(clk), .rst(rst), .div_sel(cfg.div_sel), .clr(div_clr),
        .in_up(ev_up), .in_dn(ev_dn), .out_up(cnt_up), .out_dn(cnt_dn)
    );

    qdec_counter u_cnt (
        .clk(clk), .rst(rst), .inc(cnt_up), .dec(cnt_dn), .reload(cnt_reload),
        .start_val(cfg.start_val), .limit_val(cfg.limit_val), .cnt(cnt)
    );

    qdec_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cnt(cnt), .bad_ev(ev_bad), .cfg(cfg), .div_clr(div_clr),
        .cnt_reload(cnt_reload), .rdata(bus_rdata)
    );

    // R6: with decoding off only a reload may move the count
    p_qen_off_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg.qen && !cnt_reload) |=> $stable(cnt));
endmodule

// File: tb/tb_quad_pos_counter.sv
module tb_quad_pos_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int gpos     = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    quad_pos_counter dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Gray positions 0..3 map to {A,B} = 00,01,11,10
    task automatic set_pos(input int p);
        gpos = p & 3;
        @(negedge clk);
        enc_a = (gpos >= 2);
        enc_b = (gpos == 1) || (gpos == 2);
        repeat (5) @(posedge clk);
    endtask

    task automatic steps(input int n, input bit up);
        for (int i = 0; i < n; i++) set_pos(up ? gpos + 1 : gpos + 3);
    endtask

    task automatic t_reset();
        expect_reg("R1 count", 8'h00, 32'h0);
        expect_reg("R1 start", 8'h04, 32'h0);
        expect_reg("R1 limit", 8'h08, 32'hFFFF);
        expect_reg("R1 div", 8'h0C, 32'h0);
        expect_reg("R1 mode", 8'h10, 32'h0);
        expect_reg("R1 qctl", 8'h14, 32'h0);
        expect_reg("R1 status", 8'h18, 32'h0);
        expect_reg("R11 unmapped", 8'h1C, 32'h0);
    endtask

    task automatic t_disabled();
        steps(3, 1'b1);
        expect_reg("R6 edges ignored when off", 8'h00, 32'h0);
    endtask

    task automatic t_decode();
        wr(8'h10, 32'h1);
        wr(8'h14, 32'h1);
        expect_reg("R11 mode readback", 8'h10, 32'h1);
        steps(4, 1'b1);
        expect_reg("R2 up x4", 8'h00, 32'd4);
        steps(3, 1'b0);
        expect_reg("R2 down", 8'h00, 32'd1);
        steps(2, 1'b0);
        expect_reg("R4 down wrap 0 to FFFF", 8'h00, 32'hFFFF);
        steps(1, 1'b1);
        expect_reg("R4 up wrap FFFF to 0", 8'h00, 32'h0);
    endtask

    task automatic t_reload_wrap();
        wr(8'h04, 32'hABCD0010);
        wr(8'h08, 32'h13);
        expect_reg("R9 start written", 8'h04, 32'h10);
        wr(8'h00, 32'h1234);
        expect_reg("R3 reload ignores data", 8'h00, 32'h10);
        steps(3, 1'b1);
        expect_reg("R2 up to limit", 8'h00, 32'h13);
        steps(1, 1'b1);
        expect_reg("R4 up wrap to start", 8'h00, 32'h10);
        steps(1, 1'b0);
        expect_reg("R4 down wrap to limit", 8'h00, 32'h13);
    endtask

    task automatic t_prescale();
        wr(8'h08, 32'hFFFF);
        wr(8'h04, 32'h100);
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h2);
        steps(3, 1'b1);
        expect_reg("R5 three of four events", 8'h00, 32'h100);
        steps(1, 1'b1);
        expect_reg("R5 fourth event counts", 8'h00, 32'h101);
        steps(2, 1'b1);
        wr(8'h0C, 32'h2);
        steps(3, 1'b1);
        expect_reg("R5 accumulator cleared by write", 8'h00, 32'h101);
        steps(1, 1'b1);
        expect_reg("R5 count after clear", 8'h00, 32'h102);
        wr(8'h0C, 32'h0);
    endtask

    task automatic t_illegal();
        set_pos(gpos + 2);
        expect_reg("R10 count unchanged", 8'h00, 32'h102);
        expect_reg("R10 error flag", 8'h18, 32'h2);
        steps(1, 1'b1);
        expect_reg("R10 error sticky", 8'h18, 32'h2);
        expect_reg("R2 counts after bad step", 8'h00, 32'h103);
    endtask

    task automatic t_men();
        wr(8'h10, 32'h0);
        wr(8'h04, 32'h55);
        wr(8'h08, 32'h66);
        expect_reg("R9 start held", 8'h04, 32'h100);
        expect_reg("R9 limit held", 8'h08, 32'hFFFF);
        wr(8'h10, 32'h1);
    endtask

    task automatic t_lock();
        wr(8'h18, 32'h1);
        expect_reg("R7 lock readable", 8'h18, 32'h3);
        wr(8'h0C, 32'h5);
        expect_reg("R7 div held", 8'h0C, 32'h0);
        wr(8'h14, 32'h0);
        expect_reg("R7 qctl held", 8'h14, 32'h1);
        wr(8'h04, 32'h77);
        expect_reg("R7 start held", 8'h04, 32'h100);
        wr(8'h10, 32'h0);
        expect_reg("R7 mode held", 8'h10, 32'h1);
        steps(1, 1'b1);
        expect_reg("R7 still counting", 8'h00, 32'h104);
        wr(8'h00, 32'h0);
        expect_reg("R3 reload while locked", 8'h00, 32'h100);
        wr(8'h10, 32'h4);
        expect_reg("R8 lock cleared", 8'h18, 32'h2);
        expect_reg("R8 men kept", 8'h10, 32'h1);
        wr(8'h0C, 32'h1);
        expect_reg("R8 div writable again", 8'h0C, 32'h1);
    endtask

    task automatic t_stop();
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        steps(4, 1'b0);
        expect_reg("R6 stopped", 8'h00, 32'h100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_disabled();
        t_decode();
        t_reload_wrap();
        t_prescale();
        t_illegal();
        t_men();
        t_lock();
        t_stop();
        done = 1'b1;
        report();
    end
endmodule